// File: doc/BRIEF.md
# Dual Overflow-Interrupt Up-Counting Timer

This peripheral holds two identical 32-bit timers behind a small word-oriented register bus. Each timer counts upward from a programmable start value. When its count passes all-ones it raises a pending flag, reloads the start value and keeps counting. To arm an event after roughly `delta` ticks, software loads `0xFFFF_FFFF - delta` as the start value. A free-running time base is obtained by loading zero and reading the live count. A per-timer prescaler slows the count, and one interrupt line combines the unmasked pending flags of both timers.

Each timer is driven by a three-state machine:
- `CH_IDLE`: the count is frozen.
- `CH_HOLD`: the count is stopped and follows the start value.
- `CH_RUN`: the count advances on prescaler ticks while the enable bit is set.

Every transition is caused by a write to the control register:
- **hold** (bit 0 set) goes to `CH_HOLD` from any state.
- **go** (bit 0 clear, bit 1 set) goes to `CH_RUN`.
- **halt** (both bits clear) goes to `CH_IDLE`.

Any other access leaves the state unchanged.

Top module: `ovf_timer_pair`

## Requirements
- R1: After reset, every register of both timers reads 0 and `irq` is 0.
- R2: A 10-bit byte address selects the timer with bits [9:6] (0 = first timer, 1 = second timer, any other value is unmapped) and the register with bits [5:2]. Bits [1:0] are ignored. The register offsets are: 0x00 pending flag, 0x04 live count (read-only), 0x10 control, 0x20 configuration, 0x24 prescaler, 0x28 start value. Unmapped offsets and timers read 0, and writes to them change nothing.
- R3: Writing control with bit 0 set enters `CH_HOLD`. From the next clock on, the count equals the start value and follows later writes to it. Bit 0 wins over bit 1, and control then reads back 1.
- R4: Writing control = 2 enters `CH_RUN` (control reads back 2). With configuration bit 0 (enable) set and prescaler 0, the count rises by one on every clock, starting at the edge after the write.
- R5: With prescaler value N, a running timer advances once every N+1 clocks. The first increment comes N+1 clocks after the go write.
- R6: A running timer whose count is 0xFFFF_FFFF reloads the start value on its next tick, sets pending flag bit 0, and keeps counting from there.
- R7: Writing 1 to pending bit 0 clears the flag, and writing 0 leaves it unchanged. If an overflow occurs in the same cycle as a clear write, the flag stays set.
- R8: `irq` is the OR over both timers of (pending flag AND configuration bit 1).
- R9: Writing control = 0, or clearing configuration bit 0, freezes the count.
- R10: The two timers are independent. Activity in one never changes the registers of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not reading) |
| irq | output | 1 | Combined overflow interrupt |

## Verification
A software clear of the pending flag and a hardware overflow can land on the same clock edge, and the flag must then remain set so that no event is lost. The bench arms a timer with a start value three below all-ones and the prescaler at zero. From the go write it counts the clock edges exactly, then places the clear write on the fourth edge, which is the edge where the overflow occurs. It then checks that the flag reads 1 and the count has reloaded. A later clear with no overflow pending confirms that the clear path itself still works.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HOLD = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    // word offsets inside one timer window
    localparam logic [3:0] WOFF_PEND  = 4'h0;
    localparam logic [3:0] WOFF_LIVE  = 4'h1;
    localparam logic [3:0] WOFF_CTL   = 4'h4;
    localparam logic [3:0] WOFF_CFG   = 4'h8;
    localparam logic [3:0] WOFF_PRE   = 4'h9;
    localparam logic [3:0] WOFF_START = 4'hA;

    localparam int CTL_HOLD_BIT = 0;
    localparam int CTL_GO_BIT   = 1;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_IEN_BIT  = 1;

endpackage

// File: rtl/otp_prescaler.sv
module otp_prescaler #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    assign tick = run && (phase_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/otp_channel.sv
module otp_channel
    import otp_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_sel,
    input  logic             acc_wr,
    input  logic [3:0]       woff,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             irq_req,
    output logic [1:0]       dbg_state,
    output logic [CNT_W-1:0] dbg_count,
    output logic [CNT_W-1:0] dbg_start,
    output logic             dbg_pend,
    output logic             dbg_tick,
    output logic             dbg_wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ch_state_e        state_q, state_d;
    logic             en_q, ien_q, pend_q;
    logic [DIV_W-1:0] pre_q;
    logic [CNT_W-1:0] start_q, count_q;
    logic             tick, wrap, run;
    logic             wr_hit, ctl_wr, cfg_wr, pre_wr, start_wr, pend_wr;

    assign wr_hit   = acc_sel && acc_wr;
    assign ctl_wr   = wr_hit && (woff == WOFF_CTL);
    assign cfg_wr   = wr_hit && (woff == WOFF_CFG);
    assign pre_wr   = wr_hit && (woff == WOFF_PRE);
    assign start_wr = wr_hit && (woff == WOFF_START);
    assign pend_wr  = wr_hit && (woff == WOFF_PEND);

    assign run  = (state_q == CH_RUN) && en_q;
    assign wrap = (state_q == CH_RUN) && tick && (count_q == CNT_MAX);

    otp_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (pre_q),
        .tick  (tick)
    );

    // next-state: hold wins over go, neither means halt
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            unique casez ({wdata[CTL_GO_BIT], wdata[CTL_HOLD_BIT]})
                2'b?1:   state_d = CH_HOLD;
                2'b10:   state_d = CH_RUN;
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // counter action per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: count_q <= count_q;
                CH_HOLD: count_q <= start_q;
                CH_RUN: begin
                    if (wrap)      count_q <= start_q;
                    else if (tick) count_q <= count_q + 1'b1;
                end
                default: count_q <= count_q;
            endcase
        end
    end

    // pending flag: overflow set beats software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    pend_q <= 1'b0;
        else if (wrap)                 pend_q <= 1'b1;
        else if (pend_wr && wdata[0])  pend_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ien_q   <= 1'b0;
            pre_q   <= '0;
            start_q <= '0;
        end else begin
            if (cfg_wr) begin
                en_q  <= wdata[CFG_EN_BIT];
                ien_q <= wdata[CFG_IEN_BIT];
            end
            if (pre_wr)   pre_q   <= wdata[DIV_W-1:0];
            if (start_wr) start_q <= wdata[CNT_W-1:0];
        end
    end

    // output process: read mux
    always_comb begin
        rdata = '0;
        unique case (woff)
            WOFF_PEND:  rdata = REG_W'(pend_q);
            WOFF_LIVE:  rdata = REG_W'(count_q);
            WOFF_CTL:   rdata = REG_W'({state_q == CH_RUN, state_q == CH_HOLD});
            WOFF_CFG:   rdata = REG_W'({ien_q, en_q});
            WOFF_PRE:   rdata = REG_W'(pre_q);
            WOFF_START: rdata = REG_W'(start_q);
            default:    rdata = '0;
        endcase
    end

    assign irq_req   = pend_q && ien_q;
    assign dbg_state = state_q;
    assign dbg_count = count_q;
    assign dbg_start = start_q;
    assign dbg_pend  = pend_q;
    assign dbg_tick  = tick;
    assign dbg_wrap  = wrap;

endmodule

// File: rtl/ovf_timer_pair.sv
module ovf_timer_pair
    import otp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    localparam int CH_LSB = 6;
    localparam int IDX_W  = ADDR_W - CH_LSB;

    logic [IDX_W-1:0]             ch_idx;
    logic [3:0]                   ch_woff;
    logic                         unused_lsb;
    logic [NUM_CH-1:0][REG_W-1:0] ch_rdata;
    logic [NUM_CH-1:0]            ch_irq;
    logic [NUM_CH-1:0][1:0]       ch_state;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0] ch_start;
    logic [NUM_CH-1:0]            ch_pend;
    logic [NUM_CH-1:0]            ch_tick;
    logic [NUM_CH-1:0]            ch_wrap;

    assign ch_idx     = bus_addr[ADDR_W-1:CH_LSB];
    assign ch_woff    = bus_addr[CH_LSB-1:2];
    assign unused_lsb = ^bus_addr[1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
        otp_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_sel   (bus_sel && (ch_idx == IDX_W'(g))),
            .acc_wr    (bus_wr),
            .woff      (ch_woff),
            .wdata     (bus_wdata),
            .rdata     (ch_rdata[g]),
            .irq_req   (ch_irq[g]),
            .dbg_state (ch_state[g]),
            .dbg_count (ch_count[g]),
            .dbg_start (ch_start[g]),
            .dbg_pend  (ch_pend[g]),
            .dbg_tick  (ch_tick[g]),
            .dbg_wrap  (ch_wrap[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == IDX_W'(i)) bus_rdata = ch_rdata[i];
            end
        end
    end

    assign irq = |ch_irq;

endmodule

// File: rtl/otp_checker.sv
module otp_checker
    import otp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0][1:0]       st,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] start,
    input logic [NUM_CH-1:0]            pend,
    input logic [NUM_CH-1:0]            tick,
    input logic [NUM_CH-1:0]            wrap
);

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_chk
        // R3
        hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == CH_HOLD) |=> (cnt[g] == $past(start[g])));

        // R6
        wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[g] |=> (pend[g] && (cnt[g] == $past(start[g]))));

        // R7
        pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[g]) |-> $past(wrap[g]));

        // R9
        idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == CH_IDLE) |=> $stable(cnt[g]));

        // R5
        no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((st[g] == CH_RUN) && !tick[g]) |=> $stable(cnt[g]));
    end

endmodule

bind ovf_timer_pair otp_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_otp_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .st    (ch_state),
    .cnt   (ch_count),
    .start (ch_start),
    .pend  (ch_pend),
    .tick  (ch_tick),
    .wrap  (ch_wrap)
);

// File: tb/test_ovf_timer_pair.sv
`timescale 1ns/1ps
module test_ovf_timer_pair;

    localparam logic [9:0] C0 = 10'h000, C1 = 10'h040;
    localparam logic [9:0] PEND = 10'h00, LIVE = 10'h04, CTL = 10'h10,
                           CFG = 10'h20, PRE = 10'h24, STRT = 10'h28;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ovf_timer_pair i_ovf_timer_pair (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; captured on the next rising edge
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // 1 ns read, no clock consumed
    task automatic rdc(input string req, input logic [9:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        chk(req, $sformatf("addr %h", a), bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    task automatic rdv(input logic [9:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // read then realign to the next falling edge
    task automatic rdcs(input string req, input logic [9:0] a, input logic [31:0] exp);
        rdc(req, a, exp);
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        foreach (bus_addr[i]) ; // no-op keeps loop vars local
        for (int c = 0; c < 2; c++) begin
            logic [9:0] b = (c == 0) ? C0 : C1;
            rdcs("R1", b | PEND, 0); rdcs("R1", b | LIVE, 0); rdcs("R1", b | CTL, 0);
            rdcs("R1", b | CFG, 0);  rdcs("R1", b | PRE, 0);  rdcs("R1", b | STRT, 0);
        end
        chk("R1", "irq after reset", irq, 0);
    endtask

    task automatic t_decode();
        wr(C0 | STRT, 32'h1234); wr(C1 | STRT, 32'hA5A5_0000);
        wr(C0 | PRE, 7); wr(C1 | CFG, 3);
        rdcs("R2", C0 | STRT, 32'h1234); rdcs("R10", C1 | STRT, 32'hA5A5_0000);
        rdcs("R2", C0 | PRE, 7); rdcs("R10", C1 | PRE, 0);
        rdcs("R2", C1 | CFG, 3); rdcs("R10", C0 | CFG, 0);
        wr(C0 | LIVE, 32'hFFFF);
        rdcs("R2", C0 | LIVE, 0);
        rdcs("R2", 10'h008, 0);
        wr(10'h0A8, 32'h55);
        rdcs("R2", 10'h0A8, 0);
        rdcs("R2", C0 | STRT, 32'h1234);
        rdcs("R2", C0 | 10'h02B, 32'h1234);
        wr(C1 | CFG, 0); wr(C0 | PRE, 0);
    endtask

    task automatic t_hold();
        wr(C0 | CTL, 1);
        @(negedge clk);
        rdcs("R3", C0 | LIVE, 32'h1234);
        wr(C0 | STRT, 32'h2000);
        @(negedge clk);
        rdcs("R3", C0 | LIVE, 32'h2000);
        wr(C0 | CTL, 3);
        rdcs("R3", C0 | CTL, 1);
        wr(C0 | CFG, 1);
        wait_n(2);
        rdcs("R3", C0 | LIVE, 32'h2000);
    endtask

    task automatic t_count();
        wr(C0 | CTL, 2);
        rdc("R4", C0 | LIVE, 32'h2000);
        rdc("R4", C0 | CTL, 2);
        wait_n(5);
        rdc("R4", C0 | LIVE, 32'h2005);
        @(negedge clk);
    endtask

    task automatic t_pause();
        logic [31:0] v, w;
        wr(C0 | CTL, 0);
        rdv(C0 | LIVE, v);
        wait_n(4);
        rdc("R9", C0 | LIVE, v);
        @(negedge clk);
        wr(C0 | CTL, 2);
        wr(C0 | CFG, 0);
        rdv(C0 | LIVE, w);
        wait_n(4);
        rdc("R9", C0 | LIVE, w);
        @(negedge clk);
        wr(C0 | CFG, 1);
    endtask

    task automatic t_div();
        wr(C0 | CTL, 1); wr(C0 | STRT, 100); wr(C0 | PRE, 2);
        @(negedge clk);
        rdc("R5", C0 | LIVE, 100);
        @(negedge clk);
        wr(C0 | CTL, 2);
        wait_n(2);
        rdc("R5", C0 | LIVE, 100);
        wait_n(6);
        rdc("R5", C0 | LIVE, 102);
        @(negedge clk);
        rdc("R5", C0 | LIVE, 103);
        @(negedge clk);
        wr(C0 | CTL, 0);
    endtask

    task automatic t_wrap();
        wr(C0 | CTL, 1); wr(C0 | CFG, 3); wr(C0 | PRE, 0); wr(C0 | STRT, 32'hFFFF_FFFC);
        @(negedge clk);
        wr(C0 | CTL, 2);
        wait_n(3);
        rdc("R6", C0 | LIVE, 32'hFFFF_FFFF);
        rdc("R6", C0 | PEND, 0);
        chk("R8", "irq before wrap", irq, 0);
        @(negedge clk);
        rdc("R6", C0 | LIVE, 32'hFFFF_FFFC);
        rdc("R6", C0 | PEND, 1);
        chk("R8", "irq after wrap", irq, 1);
        @(negedge clk);
        rdc("R6", C0 | LIVE, 32'hFFFF_FFFD);
        @(negedge clk);
        wr(C0 | CTL, 0);
    endtask

    task automatic t_clear();
        wr(C0 | PEND, 0);
        rdcs("R7", C0 | PEND, 1);
        wr(C0 | PEND, 1);
        rdcs("R7", C0 | PEND, 0);
        chk("R8", "irq after clear", irq, 0);
    endtask

    task automatic t_collide();
        wr(C0 | CTL, 1);
        @(negedge clk);
        wr(C0 | CTL, 2);
        wait_n(3);
        wr(C0 | PEND, 1);
        rdc("R7", C0 | PEND, 1);
        rdc("R7", C0 | LIVE, 32'hFFFF_FFFC);
        @(negedge clk);
        wr(C0 | CTL, 0);
        wr(C0 | PEND, 1);
        rdcs("R7", C0 | PEND, 0);
    endtask

    task automatic t_mask_or();
        wr(C0 | CTL, 1); wr(C0 | CFG, 1);
        @(negedge clk);
        wr(C0 | CTL, 2);
        wait_n(4);
        wr(C0 | CTL, 0);
        rdcs("R6", C0 | PEND, 1);
        chk("R8", "irq masked", irq, 0);
        wr(C1 | STRT, 32'hFFFF_FFFE); wr(C1 | CFG, 3); wr(C1 | CTL, 1);
        @(negedge clk);
        wr(C1 | CTL, 2);
        wait_n(2);
        chk("R8", "irq from second timer", irq, 1);
        wr(C1 | CTL, 0);
        wr(C0 | CFG, 3);
        chk("R8", "irq both pending", irq, 1);
        wr(C1 | PEND, 1);
        chk("R8", "irq first still pending", irq, 1);
        wr(C0 | PEND, 1);
        chk("R8", "irq none pending", irq, 0);
    endtask

    task automatic t_timesource();
        logic [31:0] v;
        rdv(C0 | LIVE, v);
        @(negedge clk);
        wr(C1 | STRT, 0); wr(C1 | CFG, 1); wr(C1 | CTL, 1);
        @(negedge clk);
        wr(C1 | CTL, 2);
        wait_n(10);
        rdc("R4", C1 | LIVE, 10);
        rdc("R10", C0 | LIVE, v);
        rdc("R10", C0 | PEND, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_hold();
        t_count();
        t_pause();
        t_div();
        t_wrap();
        t_clear();
        t_collide();
        t_mask_or();
        t_timesource();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycles=20000 expected completion earlier");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule